// File: doc/BRIEF.md
# Random Bit Stream Health Monitor

This block watches raw entropy one bit at a time. A bit counts only in a cycle where `bit_valid` is high. Two kinds of check run on the bit stream. The first kind is continuous: a run counter catches long stretches of identical bits. The second kind is windowed: ones counting and 4-bit pattern counting are judged once per fixed window of valid bits. A third check sits on the assembled output words. It catches two back-to-back words that carry the same value.

Every failure sets a sticky bit in an 8-bit status vector. The bit stays set until a one-cycle `clear` pulse. A `window_done` pulse marks each window evaluation, so a supervisor can sample the windowed results at a known point. The bit positions are fixed because the logic that reads them decodes them by position.

Top module: `rng_health_monitor`

## Requirements
- R1: The status bit positions are: ones-count failure on bit 7, pattern failure on bit 6, long-run failure on bit 5, noise-run failure on bit 3 and repeated-word failure on bit 2. Bits 4, 1 and 0 always read 0. After reset, status is all zero and window_done is low.
- R2: A window is 20,000 valid bits. window_done is high for exactly one cycle: the cycle after the edge that takes the 20,000th valid bit. The windowed counts then restart from zero with the next valid bit.
- R3: At the end of each window, bit 7 is set unless the number of ones in the window is strictly greater than 9,654 and strictly less than 10,346.
- R4: Each window is split into 5,000 nibbles, in arrival order, with the first bit of each nibble as its MSB. The block counts how often each of the 16 nibble values occurs. Let S be the sum of the squared counts. At the end of the window, bit 6 is set when 16·S/5000 − 5000 is not strictly between 1.03 and 57.4, or when any count is below 200 or above 425.
- R5: Bit 5 is set on the edge that takes the 34th consecutive identical valid bit, and not before.
- R6: Bit 3 is set on the edge that takes the 48th consecutive identical valid bit, and not before.
- R7: Runs are counted across window boundaries without restarting. Cycles with bit_valid low change neither the run nor the window count, whatever bit_in holds.
- R8: Bit 2 is set when a word accepted with word_valid equals the previously accepted word. The first word after reset is never compared.
- R9: Flags are sticky. A clear pulse zeroes every flag on the next edge. If a failure event lands in the same cycle as the clear, that flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | One-cycle pulse that zeroes the sticky flags |
| bit_valid | input | 1 | Qualifies bit_in |
| bit_in | input | 1 | Raw random bit |
| word_valid | input | 1 | Qualifies word_in |
| word_in | input | 32 | Assembled output word |
| status | output | 8 | Sticky failure flags, positions per R1 |
| window_done | output | 1 | One-cycle pulse after each window evaluation |

## Verification
The collision of interest is a clear pulse arriving in the same cycle as a new failure event. Without care, the clear could swallow the new failure. The bench drives a clear together with the 34th identical bit, and again together with a repeated word. It then requires the matching flag to read set while the other flags read zero. The windowed failures are judged the same way at the window's closing edge: the reference tally in the bench must agree with the status vector in the very cycle that window_done is high.

// File: rtl/rhm_pkg.sv
package rhm_pkg;
   localparam int STAT_W    = 8;
   localparam int POS_MONO  = 7;
   localparam int POS_POKER = 6;
   localparam int POS_LONG  = 5;
   localparam int POS_RUNS  = 4;
   localparam int POS_NOISE = 3;
   localparam int POS_STUCK = 2;
   localparam logic [STAT_W-1:0] IMPL_MASK = 8'b1110_1100;
   localparam int NBINS     = 16;
endpackage

// File: rtl/rhm_run_tracker.sv
module rhm_run_tracker #(
   parameter int LONG_RUN  = 34,
   parameter int NOISE_RUN = 48
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_valid,
   input  logic bit_in,
   output logic long_evt,
   output logic noise_evt
);
   localparam int RUN_W = $clog2(NOISE_RUN + 1);

   logic [RUN_W-1:0] run_q, run_nx;
   logic             prev_q;

   always_comb begin
      run_nx = run_q;
      if (bit_valid) begin
         if (run_q == '0 || bit_in != prev_q)
            run_nx = RUN_W'(1);
         else if (run_q != RUN_W'(NOISE_RUN))
            run_nx = run_q + RUN_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= '0;
         prev_q <= 1'b0;
      end else if (bit_valid) begin
         run_q  <= run_nx;
         prev_q <= bit_in;
      end
   end

   assign long_evt  = bit_valid && (run_nx >= RUN_W'(LONG_RUN));
   assign noise_evt = bit_valid && (run_nx >= RUN_W'(NOISE_RUN));
endmodule

// File: rtl/rhm_monobit.sv
module rhm_monobit #(
   parameter int WINDOW_BITS = 20000,
   parameter int MONO_LO     = 9654,
   parameter int MONO_HI     = 10346
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_valid,
   input  logic bit_in,
   input  logic win_last,
   output logic fail_evt
);
   localparam int ONES_W = $clog2(WINDOW_BITS + 1);

   logic [ONES_W-1:0] ones_q, ones_nx;

   assign ones_nx = ones_q + ONES_W'(bit_valid & bit_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ones_q <= '0;
      else if (win_last) ones_q <= '0;
      else               ones_q <= ones_nx;
   end

   assign fail_evt = win_last &&
                     !((ones_nx > ONES_W'(MONO_LO)) && (ones_nx < ONES_W'(MONO_HI)));
endmodule

// File: rtl/rhm_poker.sv
module rhm_poker
   import rhm_pkg::*;
#(
   parameter int WINDOW_BITS   = 20000,
   parameter int BIN_LO        = 200,
   parameter int BIN_HI        = 425,
   parameter int POKER_LO_X100 = 103,
   parameter int POKER_HI_X10  = 574
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_valid,
   input  logic bit_in,
   input  logic win_last,
   output logic fail_evt
);
   localparam int     NIBS   = WINDOW_BITS / 4;
   localparam int     BIN_W  = $clog2(NIBS + 1);
   localparam longint MAX_SQ = longint'(NIBS) * longint'(NIBS);
   localparam int     SQ_W   = $clog2(MAX_SQ + 1);
   // 16*S/NIBS - NIBS > lo  <=>  1600*S > NIBS*(100*NIBS + lo*100)
   localparam longint LO_NUM = longint'(NIBS) * (100 * longint'(NIBS) + longint'(POKER_LO_X100));
   localparam longint SQ_MIN = LO_NUM / 1600 + 1;
   // 16*S/NIBS - NIBS < hi  <=>  160*S < NIBS*(10*NIBS + hi*10)
   localparam longint HI_NUM = longint'(NIBS) * (10 * longint'(NIBS) + longint'(POKER_HI_X10));
   localparam longint SQ_MAX = (HI_NUM + 159) / 160 - 1;

   logic [1:0]       phase_q;
   logic [2:0]       sh_q;
   logic [3:0]       nib;
   logic             nib_done;
   logic [SQ_W-1:0]  sq_q, sq_nx;
   logic [BIN_W-1:0] bin_q [NBINS];
   logic [BIN_W-1:0] sel_cnt;
   logic [NBINS-1:0] bin_bad;

   assign nib      = {sh_q, bit_in};
   assign nib_done = bit_valid && (phase_q == 2'd3);
   assign sel_cnt  = bin_q[nib];
   // (c+1)^2 - c^2 = 2c+1
   assign sq_nx    = sq_q + (nib_done ? SQ_W'({sel_cnt, 1'b1}) : '0);

   for (genvar i = 0; i < NBINS; i++) begin : g_bin
      logic             hit;
      logic [BIN_W-1:0] cnt_q, cnt_nx;
      assign hit        = nib_done && (nib == 4'(i));
      assign cnt_nx     = cnt_q + BIN_W'(hit);
      assign bin_bad[i] = (cnt_nx < BIN_W'(BIN_LO)) || (cnt_nx > BIN_W'(BIN_HI));
      assign bin_q[i]   = cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        cnt_q <= '0;
         else if (win_last) cnt_q <= '0;
         else if (hit)      cnt_q <= cnt_nx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         sh_q    <= '0;
         sq_q    <= '0;
      end else if (win_last) begin
         phase_q <= '0;
         sh_q    <= '0;
         sq_q    <= '0;
      end else if (bit_valid) begin
         phase_q <= phase_q + 2'd1;
         sh_q    <= nib[2:0];
         sq_q    <= sq_nx;
      end
   end

   assign fail_evt = win_last &&
                     ((|bin_bad) || (sq_nx < SQ_W'(SQ_MIN)) || (sq_nx > SQ_W'(SQ_MAX)));
endmodule

// File: rtl/rhm_stuck_word.sv
module rhm_stuck_word #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_valid,
   input  logic [WORD_W-1:0] word_in,
   output logic              stuck_evt
);
   logic [WORD_W-1:0] prev_q;
   logic              have_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         have_q <= 1'b0;
      end else if (word_valid) begin
         prev_q <= word_in;
         have_q <= 1'b1;
      end
   end

   assign stuck_evt = word_valid && have_q && (word_in == prev_q);
endmodule

// File: rtl/rng_health_monitor.sv
module rng_health_monitor
   import rhm_pkg::*;
#(
   parameter int WINDOW_BITS   = 20000,
   parameter int MONO_LO       = 9654,
   parameter int MONO_HI       = 10346,
   parameter int BIN_LO        = 200,
   parameter int BIN_HI        = 425,
   parameter int POKER_LO_X100 = 103,
   parameter int POKER_HI_X10  = 574,
   parameter int LONG_RUN      = 34,
   parameter int NOISE_RUN     = 48,
   parameter int WORD_W        = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              bit_valid,
   input  logic              bit_in,
   input  logic              word_valid,
   input  logic [WORD_W-1:0] word_in,
   output logic [7:0]        status,
   output logic              window_done
);
   localparam int IDX_W = $clog2(WINDOW_BITS);

   if (WINDOW_BITS % 4 != 0 || WINDOW_BITS < 8) begin : g_bad_window
      $error("WINDOW_BITS must be a multiple of 4 and at least 8");
   end
   if (LONG_RUN < 2 || LONG_RUN >= NOISE_RUN) begin : g_bad_runs
      $error("LONG_RUN must be at least 2 and below NOISE_RUN");
   end
   if (MONO_LO >= MONO_HI || MONO_HI > WINDOW_BITS) begin : g_bad_mono
      $error("monobit band is empty or wider than the window");
   end
   if (BIN_LO > BIN_HI) begin : g_bad_bins
      $error("pattern count band is empty");
   end

   logic [IDX_W-1:0]  idx_q;
   logic              win_last;
   logic              done_q;
   logic [STAT_W-1:0] evt;
   logic              mono_evt, poker_evt, long_evt, noise_evt, stuck_evt;

   assign win_last = bit_valid && (idx_q == IDX_W'(WINDOW_BITS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= win_last;
         if (win_last)       idx_q <= '0;
         else if (bit_valid) idx_q <= idx_q + IDX_W'(1);
      end
   end

   rhm_run_tracker #(.LONG_RUN(LONG_RUN), .NOISE_RUN(NOISE_RUN)) u_run (
      .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
      .long_evt(long_evt), .noise_evt(noise_evt));

   rhm_monobit #(.WINDOW_BITS(WINDOW_BITS), .MONO_LO(MONO_LO), .MONO_HI(MONO_HI)) u_mono (
      .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
      .win_last(win_last), .fail_evt(mono_evt));

   rhm_poker #(.WINDOW_BITS(WINDOW_BITS), .BIN_LO(BIN_LO), .BIN_HI(BIN_HI),
               .POKER_LO_X100(POKER_LO_X100), .POKER_HI_X10(POKER_HI_X10)) u_poker (
      .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
      .win_last(win_last), .fail_evt(poker_evt));

   rhm_stuck_word #(.WORD_W(WORD_W)) u_stuck (
      .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_in(word_in),
      .stuck_evt(stuck_evt));

   always_comb begin
      evt            = '0;
      evt[POS_MONO]  = mono_evt;
      evt[POS_POKER] = poker_evt;
      evt[POS_LONG]  = long_evt;
      evt[POS_NOISE] = noise_evt;
      evt[POS_STUCK] = stuck_evt;
   end

   for (genvar i = 0; i < STAT_W; i++) begin : g_flag
      if (IMPL_MASK[i]) begin : g_live
         logic flag_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_q <= 1'b0;
            else        flag_q <= (flag_q & ~clear) | evt[i];
         end
         assign status[i] = flag_q;
      end else begin : g_tied
         assign status[i] = 1'b0;
      end
   end

   assign window_done = done_q;
endmodule

// File: rtl/rhm_health_checker.sv
module rhm_health_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       clear,
   input logic       bit_valid,
   input logic       word_valid,
   input logic [7:0] status,
   input logic       window_done
);
   p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      window_done |=> !window_done);

   p_done_after_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      window_done |-> $past(bit_valid));

   p_mono_at_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[7]) |-> window_done);

   p_poker_at_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[6]) |-> window_done);

   p_long_after_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[5]) |-> $past(bit_valid));

   p_noise_after_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[3]) |-> $past(bit_valid));

   p_stuck_after_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[2]) |-> $past(word_valid));

   p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> ((status & $past(status)) == $past(status)));

   p_clear_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !bit_valid && !word_valid) |=> (status == 8'h00));
endmodule

bind rng_health_monitor rhm_health_checker u_health_chk (
   .clk(clk), .rst_n(rst_n), .clear(clear), .bit_valid(bit_valid),
   .word_valid(word_valid), .status(status), .window_done(window_done));

// File: tb/rng_health_monitor_tb_top.sv
`timescale 1ns/1ps
module rng_health_monitor_tb_top;
   localparam int WIN = 20000;

   typedef struct packed {
      logic [1:0]  mode;
      logic [31:0] seed;
      logic        pinned;
      logic        exp_mono;
      logic        exp_poker;
   } win_vec_t;

   // mode 0: xorshift bits with idle gaps, 1: nibble ramp 0..15, 2: nibble 0111 repeated
   localparam win_vec_t WIN_TAB [4] = '{
      '{2'd0, 32'h1234_5678, 1'b0, 1'b0, 1'b0},
      '{2'd1, 32'h0,         1'b1, 1'b0, 1'b1},
      '{2'd2, 32'h0,         1'b1, 1'b1, 1'b1},
      '{2'd0, 32'h0BAD_F00D, 1'b0, 1'b0, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clear = 1'b0;
   logic        bit_valid = 1'b0;
   logic        bit_in = 1'b0;
   logic        word_valid = 1'b0;
   logic [31:0] word_in = '0;
   logic [7:0]  status;
   logic        window_done;

   int n_chk = 0;
   int n_err = 0;

   // reference model state
   int          m_run, m_cnt, m_ones;
   int          m_bins [16];
   logic        m_prev;
   logic [3:0]  m_nib;
   logic [7:0]  m_flags;
   logic        m_have;
   logic [31:0] m_word;

   always #10 clk = ~clk;

   rng_health_monitor dut_i (
      .clk(clk), .rst_n(rst_n), .clear(clear), .bit_valid(bit_valid), .bit_in(bit_in),
      .word_valid(word_valid), .word_in(word_in), .status(status), .window_done(window_done));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic m_reset();
      m_run = 0; m_cnt = 0; m_ones = 0; m_prev = 1'b0; m_nib = '0;
      m_flags = '0; m_have = 1'b0; m_word = '0;
      for (int i = 0; i < 16; i++) m_bins[i] = 0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      m_reset();
   endtask

   task automatic m_window();
      longint s = 0;
      logic   pk = 1'b0;
      for (int i = 0; i < 16; i++) begin
         s += longint'(m_bins[i]) * m_bins[i];
         if (m_bins[i] < 200 || m_bins[i] > 425) pk = 1'b1;
      end
      if (s * 1600 <= 64'd5000 * 64'd500103) pk = 1'b1;
      if (s * 160  >= 64'd5000 * 64'd50574)  pk = 1'b1;
      if (pk) m_flags[6] = 1'b1;
      if (!(m_ones > 9654 && m_ones < 10346)) m_flags[7] = 1'b1;
      m_cnt = 0; m_ones = 0;
      for (int i = 0; i < 16; i++) m_bins[i] = 0;
   endtask

   task automatic send_bit(input logic b, input logic c);
      bit_in = b; bit_valid = 1'b1; clear = c;
      @(negedge clk);
      bit_valid = 1'b0; clear = 1'b0;
      if (c) m_flags = '0;
      if (m_run == 0 || b != m_prev) m_run = 1;
      else if (m_run < 48) m_run++;
      m_prev = b;
      if (m_run >= 34) m_flags[5] = 1'b1;
      if (m_run >= 48) m_flags[3] = 1'b1;
      m_cnt++; m_ones += int'(b); m_nib = {m_nib[2:0], b};
      if (m_cnt % 4 == 0) m_bins[m_nib]++;
      if (m_cnt == WIN - 1) chk("R2 no early done", 32'(window_done), 32'd0);
      if (m_cnt == WIN) begin
         m_window();
         chk("R2 window_done pulse", 32'(window_done), 32'd1);
         chk("R3 monobit flag", 32'(status[7]), 32'(m_flags[7]));
         chk("R4 poker flag", 32'(status[6]), 32'(m_flags[6]));
         chk("R7 status at window end", 32'(status), 32'(m_flags));
      end
   endtask

   task automatic send_word(input logic [31:0] w, input logic c);
      word_in = w; word_valid = 1'b1; clear = c;
      @(negedge clk);
      word_valid = 1'b0; clear = 1'b0;
      if (c) m_flags = '0;
      if (m_have && w == m_word) m_flags[2] = 1'b1;
      m_word = w; m_have = 1'b1;
   endtask

   task automatic do_clear();
      clear = 1'b1;
      @(negedge clk);
      clear = 1'b0;
      m_flags = '0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         bit_in = ~bit_in;
         @(negedge clk);
      end
   endtask

   function automatic logic [31:0] xs(input logic [31:0] s);
      logic [31:0] t = s;
      t ^= t << 13;
      t ^= t >> 17;
      t ^= t << 5;
      return t;
   endfunction

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_err++;
      $display("FAIL R2 watchdog act=running exp=finished");
      finish_run();
   end

   initial begin
      m_reset();
      repeat (3) @(negedge clk);
      chk("R1 reset status", 32'(status), 32'h0);
      chk("R1 reset window_done", 32'(window_done), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R5: 33 identical bits leave the long flag clear, the 34th sets it
      for (int i = 0; i < 33; i++) send_bit(1'b1, 1'b0);
      chk("R5 33 ones no flag", 32'(status), 32'(m_flags));
      for (int i = 0; i < 33; i++) send_bit(1'b0, 1'b0);
      chk("R5 33 zeros no flag", 32'(status[5]), 32'd0);
      send_bit(1'b0, 1'b0);
      chk("R5 34th zero sets flag", 32'(status[5]), 32'd1);
      do_clear();
      chk("R9 clear zeroes flags", 32'(status), 32'h0);

      // R7: idle cycles with toggling bit_in do not break a run
      for (int i = 0; i < 20; i++) send_bit(1'b1, 1'b0);
      idle(5);
      for (int i = 0; i < 13; i++) send_bit(1'b1, 1'b0);
      chk("R7 run of 33 across idle", 32'(status[5]), 32'd0);
      send_bit(1'b1, 1'b0);
      chk("R7 run of 34 across idle", 32'(status[5]), 32'd1);

      // R6: noise flag at the 48th identical bit
      for (int i = 0; i < 13; i++) send_bit(1'b1, 1'b0);
      chk("R6 47 ones no noise", 32'(status[3]), 32'd0);
      send_bit(1'b1, 1'b0);
      chk("R6 48th one sets noise", 32'(status[3]), 32'd1);

      // R9: clear coincident with the 34th identical bit
      for (int i = 0; i < 33; i++) send_bit(1'b0, 1'b0);
      send_bit(1'b0, 1'b1);
      chk("R9 set wins over clear", 32'(status), 32'h20);
      chk("R9 model agrees", 32'(status), 32'(m_flags));
      do_clear();

      // R8: word repetition
      send_word(32'h0, 1'b0);
      chk("R8 first word not compared", 32'(status[2]), 32'd0);
      send_word(32'h0, 1'b0);
      chk("R8 repeated word", 32'(status[2]), 32'd1);
      do_clear();
      send_word(32'hA5A5_0001, 1'b0);
      send_word(32'h0000_0001, 1'b0);
      chk("R8 distinct words", 32'(status[2]), 32'd0);
      send_word(32'h0000_0001, 1'b1);
      chk("R9 repeat with clear", 32'(status), 32'h04);
      chk("R1 unused bits zero", 32'(status & 8'h13), 32'h0);

      // table of windows
      do_reset();
      foreach (WIN_TAB[k]) begin
         logic [31:0] st = WIN_TAB[k].seed;
         do_clear();
         for (int i = 0; i < WIN; i++) begin
            logic b;
            case (WIN_TAB[k].mode)
               2'd0: begin st = xs(st); b = st[0]; end
               2'd1: b = 4'((i / 4) % 16) >> (3 - (i % 4));
               default: b = (i % 4) != 0;
            endcase
            if (WIN_TAB[k].mode == 2'd0 && i % 1000 == 999) idle(3);
            send_bit(b, 1'b0);
         end
         if (WIN_TAB[k].pinned) begin
            chk("R3 pinned monobit", 32'(status[7]), 32'(WIN_TAB[k].exp_mono));
            chk("R4 pinned poker", 32'(status[6]), 32'(WIN_TAB[k].exp_poker));
         end
         @(negedge clk);
         chk("R2 window_done one cycle", 32'(window_done), 32'd0);
      end

      // R7: run continues across a window boundary
      do_reset();
      for (int i = 0; i < WIN - 20; i++) send_bit(logic'(i % 2 == 0), 1'b0);
      for (int i = 0; i < 20; i++) send_bit(1'b1, 1'b0);
      chk("R7 run 20 at boundary", 32'(status[5]), 32'd0);
      for (int i = 0; i < 13; i++) send_bit(1'b1, 1'b0);
      chk("R7 run 33 crossing", 32'(status[5]), 32'd0);
      send_bit(1'b1, 1'b0);
      chk("R7 run 34 crossing", 32'(status[5]), 32'd1);
      chk("R7 full status", 32'(status), 32'(m_flags));

      finish_run();
   end
endmodule